// File: doc/BRIEF.md
# Thread Activity Update Controller

This block decides which hardware thread contexts of a multithreaded core may run. It keeps three status bits per thread: halted, activated and dynamically allocatable. It drives one run output per thread. A thread runs when its halted bit is clear and its activated bit is set. All other threads are held stopped.

Every write to the status bits raises an update request, and so does a pulse on the separate request input, which other control writes use. The first request that arrives while the block is idle is accepted. The block then waits a programmable number of cycles. After that it walks the configured threads one per clock and refreshes each thread's run bit. Requests that arrive while an evaluation is pending or in progress are absorbed into it. The busy output shows when an evaluation is outstanding.

After reset thread 0 is activated and running. Every other thread is marked dynamically allocatable and is stopped.

Top module: `thr_act_ctl`

## Requirements
- R1: After reset, act_o = 0b0001 (thread 0 activated), halt_o is all zero, dyn_o has every bit set except bit 0, run_o = 0b0001 and busy_o is low.
- R2: When wr_en is high at a clock edge, thread wr_sel takes halted = wr_halt, activated = wr_act and allocatable = wr_dyn. The new values show on halt_o, act_o and dyn_o after that edge. This happens whether or not busy_o is high.
- R3: A high upd_req or wr_en at an edge where busy_o is low is accepted. busy_o is high from the following cycle until the evaluation completes.
- R4: A request at an edge where busy_o is already high starts no further evaluation. This includes the edge on which busy_o falls. busy_o then stays low until a new request arrives.
- R5: Call the accepting edge edge 0, and let D be delay_cfg sampled at that edge. Thread k's run bit takes its new value at edge D+2+k, and holds its earlier value before that edge. busy_o falls at edge D+2+L, where L is last_thr sampled at the accepting edge (clamped to NTHR-1). The run bits do not change while busy_o is low.
- R6: When a thread is evaluated, its run bit becomes 1 if its halted bit is 0 and its activated bit is 1, using the values held at that edge. Otherwise its run bit becomes 0. The allocatable bit has no effect.
- R7: run_o bit k is 0 whenever k is greater than the current last_thr, whatever the stored run state. The stored state shows again once last_thr rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_req | input | 1 | Update request from other control writes |
| delay_cfg | input | DLY_W | Cycles to wait before evaluation starts |
| last_thr | input | IDW | Number of evaluated threads minus one |
| wr_en | input | 1 | Status write strobe; also requests an update |
| wr_sel | input | IDW | Thread whose status is written |
| wr_halt | input | 1 | Halted bit to write |
| wr_act | input | 1 | Activated bit to write |
| wr_dyn | input | 1 | Dynamically allocatable bit to write |
| halt_o | output | NTHR | Halted bit per thread |
| act_o | output | NTHR | Activated bit per thread |
| dyn_o | output | NTHR | Allocatable bit per thread |
| run_o | output | NTHR | Run (1) or halt (0) per thread |
| busy_o | output | 1 | Evaluation pending or in progress |

## Verification
A wrong delay counter or thread index moves a run bit to the wrong edge. It shows on run_o exactly at edge D+2+k, so the bench samples that edge and the one before it. A pending flag that clears too early or is not held shows on busy_o within one cycle of the last evaluation edge: busy_o rises again, or drops before the last thread is refreshed. A wrong decision rule or reset value shows on run_o as soon as the affected thread has been evaluated, or right after reset.

// File: rtl/thr_act_ctl.sv
module thr_act_ctl #(
  parameter int NTHR  = 4,
  parameter int DLY_W = 8,
  localparam int IDW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_req,
  input  logic [DLY_W-1:0] delay_cfg,
  input  logic [IDW-1:0]   last_thr,
  input  logic             wr_en,
  input  logic [IDW-1:0]   wr_sel,
  input  logic             wr_halt,
  input  logic             wr_act,
  input  logic             wr_dyn,
  output logic [NTHR-1:0]  halt_o,
  output logic [NTHR-1:0]  act_o,
  output logic [NTHR-1:0]  dyn_o,
  output logic [NTHR-1:0]  run_o,
  output logic             busy_o
);

  localparam logic [IDW-1:0]  LAST_MAX = IDW'(NTHR - 1);
  localparam logic [NTHR-1:0] ONE_HOT0 = NTHR'(1);

  logic [NTHR-1:0]  halt_q, act_q, dyn_q, run_q, keep;
  logic             busy_q, eval_q;
  logic [DLY_W-1:0] cnt_q;
  logic [IDW-1:0]   idx_q, lim_q, lim_now;
  logic             accept;

  assign accept  = (upd_req | wr_en) & ~busy_q;
  assign lim_now = (last_thr > LAST_MAX) ? LAST_MAX : last_thr;

  for (genvar k = 0; k < NTHR; k++) begin : g_keep
    localparam logic [IDW:0] KV = (IDW+1)'(k);
    assign keep[k] = KV <= {1'b0, last_thr};
  end

  assign halt_o = halt_q;
  assign act_o  = act_q;
  assign dyn_o  = dyn_q;
  assign run_o  = run_q & keep;
  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q <= '0;
      act_q  <= ONE_HOT0;
      dyn_q  <= ~ONE_HOT0;
    end else if (wr_en) begin
      halt_q[wr_sel] <= wr_halt;
      act_q[wr_sel]  <= wr_act;
      dyn_q[wr_sel]  <= wr_dyn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      eval_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      lim_q  <= '0;
      run_q  <= ONE_HOT0;
    end else if (accept) begin
      busy_q <= 1'b1;
      eval_q <= 1'b0;
      cnt_q  <= delay_cfg;
      idx_q  <= '0;
      lim_q  <= lim_now;
    end else if (busy_q) begin
      if (!eval_q) begin
        if (cnt_q == '0) eval_q <= 1'b1;
        else             cnt_q  <= cnt_q - 1'b1;
      end else begin
        run_q[idx_q] <= ~halt_q[idx_q] & act_q[idx_q];
        if (idx_q == lim_q) begin
          busy_q <= 1'b0;
          eval_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (act_q[$past(wr_sel)] == $past(wr_act) && halt_q[$past(wr_sel)] == $past(wr_halt))); // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && (upd_req || wr_en)) |=> busy_q); // R3
  AST_END_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(eval_q && idx_q == lim_q)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !eval_q && cnt_q != '0) |=> (busy_q && !eval_q && cnt_q == $past(cnt_q) - 1'b1)); // R5
  AST_WAIT_TO_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !eval_q && cnt_q == '0) |=> (eval_q && idx_q == '0)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(run_q)); // R5
  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && eval_q && (halt_q[idx_q] || !act_q[idx_q])) |=> !run_q[$past(idx_q)]); // R6

endmodule

// File: tb/thr_act_ctl_tb.sv
module thr_act_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_req = 1'b0, wr_en = 1'b0, wr_halt = 1'b0, wr_act = 1'b0, wr_dyn = 1'b0;
  logic [7:0] delay_cfg = '0;
  logic [1:0] last_thr = 2'd3, wr_sel = '0;
  logic [3:0] halt_o, act_o, dyn_o, run_o;
  logic busy_o;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  thr_act_ctl #(.NTHR(4), .DLY_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .delay_cfg(delay_cfg),
    .last_thr(last_thr), .wr_en(wr_en), .wr_sel(wr_sel), .wr_halt(wr_halt),
    .wr_act(wr_act), .wr_dyn(wr_dyn), .halt_o(halt_o), .act_o(act_o),
    .dyn_o(dyn_o), .run_o(run_o), .busy_o(busy_o));

  // {halt[3:0], act[3:0], last[1:0], delay[7:0], expected run[3:0]}
  localparam logic [21:0] VEC [8] = '{
    {4'b0000, 4'b1111, 2'd3, 8'd3, 4'b1111},
    {4'b0101, 4'b1111, 2'd3, 8'd4, 4'b1010},
    {4'b0000, 4'b0110, 2'd3, 8'd5, 4'b0110},
    {4'b0011, 4'b1110, 2'd3, 8'd3, 4'b1100},
    {4'b0000, 4'b1111, 2'd1, 8'd3, 4'b0011},
    {4'b1000, 4'b1011, 2'd2, 8'd6, 4'b0011},
    {4'b0000, 4'b1111, 2'd0, 8'd3, 4'b0001},
    {4'b1111, 4'b1111, 2'd3, 8'd3, 4'b0000}
  };

  task automatic check(string what, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic h, logic a, logic d);
    wr_en = 1'b1; wr_sel = sel; wr_halt = h; wr_act = a; wr_dyn = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy_o; i++) tick(1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 act_o", act_o, 4'b0001);
    check("R1 halt_o", halt_o, 4'b0000);
    check("R1 dyn_o", dyn_o, 4'b1110);
    check("R1 run_o", run_o, 4'b0001);
    check("R1 busy_o", busy_o, 1'b0);

    delay_cfg = 8'd9;
    wr(2'd2, 1'b1, 1'b1, 1'b0);
    check("R2 act_o", act_o, 4'b0101);
    check("R2 halt_o", halt_o, 4'b0100);
    check("R2 dyn_o", dyn_o, 4'b1010);
    wait_idle();
    check("R6 run after halted write", run_o, 4'b0001);

    for (int v = 0; v < 8; v++) begin
      last_thr  = VEC[v][13:12];
      delay_cfg = VEC[v][11:4];
      for (int t = 0; t < 4; t++) begin
        wr(2'(t), VEC[v][18+t], VEC[v][14+t], 1'b0);
        if (t == 0) check($sformatf("R3 busy after accept v%0d", v), busy_o, 1'b1);
      end
      wait_idle();
      check($sformatf("R6 R7 run vector %0d", v), run_o, VEC[v][3:0]);
    end

    last_thr = 2'd3; delay_cfg = 8'd0;
    wr(2'd2, 1'b0, 1'b1, 1'b0);
    check("R3 busy D=0", busy_o, 1'b1);
    tick(3);
    check("R5 D=0 before edge 4", run_o, 4'b0000);
    tick(1);
    check("R5 D=0 thread2 at edge 4", run_o, 4'b0100);
    check("R5 D=0 busy at edge 4", busy_o, 1'b1);
    tick(1);
    check("R5 D=0 busy clears edge 5", busy_o, 1'b0);

    delay_cfg = 8'd5;
    wr(2'd1, 1'b0, 1'b1, 1'b0);
    tick(7);
    check("R5 D=5 before edge 8", run_o, 4'b0100);
    tick(1);
    check("R5 D=5 thread1 at edge 8", run_o, 4'b0110);
    tick(1);
    check("R5 D=5 busy at edge 9", busy_o, 1'b1);
    tick(1);
    check("R5 D=5 busy clears edge 10", busy_o, 1'b0);

    delay_cfg = 8'd4;
    wr(2'd3, 1'b0, 1'b1, 1'b0);
    upd_req = 1'b1; tick(1); upd_req = 1'b0;
    wr(2'd0, 1'b0, 1'b1, 1'b0);
    upd_req = 1'b1; tick(1); upd_req = 1'b0;
    tick(5);
    upd_req = 1'b1; tick(1); upd_req = 1'b0;
    check("R4 busy falls at edge 9", busy_o, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick(1);
      check("R4 no second evaluation", busy_o, 1'b0);
    end
    check("R6 write during pending picked up", run_o, 4'b1111);

    last_thr = 2'd1; #1;
    check("R7 mask above last_thr", run_o, 4'b0011);
    last_thr = 2'd3; #1;
    check("R7 state shows again", run_o, 4'b1111);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule